// File: doc/BRIEF.md
# Master-Role Serial Clock Generator for a Stereo Converter

This block produces the three timing outputs of a stereo audio converter's serial port when the port acts as the clock master: a bit clock, a left/right channel clock and a frame-sync strobe. All three come from one master clock. A ratio select chooses 256 or 384 master clocks per sample. A 3-bit format code chooses 64 or 32 bit clocks per sample, and it also chooses how the frame-sync strobe marks the data: a one-bit pulse just ahead of the data, or a level that stays high across the data window.

A power enable input gates the whole generator. While it is low, every output is held low. When it goes high, the counters start from a fixed phase, so the first left-channel period begins a known number of master clocks later. Format codes 000 to 010 belong to the slave role, in which these signals arrive from outside. With those codes the generator stays idle.

Top module: `scg_master_clkgen`

## Requirements
- R1: While `rst_n` is low, and after reset while `pwr_on` is low, `bclk`, `lrclk` and `fsync` are all low.
- R2: The `lrclk` period is 256 master clocks when `ratio_sel`=0 and 384 when `ratio_sel`=1. `lrclk` is high for the first half of each period (left channel) and low for the second half (right channel).
- R3: Format codes 011, 100 and 101 give 64 `bclk` periods per `lrclk` period. Codes 110 and 111 give 32. `bclk` is high for exactly half of the master clocks in each period.
- R4: `lrclk` and `fsync` change only on a master clock edge where `bclk` is low after the edge. In steady running this is the falling edge of `bclk`.
- R5: One master clock edge after `pwr_on` is sampled low, all three outputs are low. They stay low while `pwr_on` stays low, whatever the current phase.
- R6: On the first master clock edge that samples `pwr_on` high, `lrclk` rises and `bclk` is low. Bit period 0 of the left channel starts at that edge.
- R7: With code 011, in each channel half `fsync` is high for exactly 16 bit periods, from bit period 1 to bit period 16 counted from the `lrclk` edge.
- R8: With codes 100, 110 and 111, `fsync` is high for exactly one bit period: the last bit period of each channel half, just before the next `lrclk` edge.
- R9: With code 101, `fsync` is high for exactly one bit period in each channel half. That bit period is the one just before the final 18 bit periods of the half.
- R10: With codes 000, 001 and 010, all outputs stay low even while `pwr_on` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Generator enable. Low holds every output low |
| ratio_sel | input | 1 | 0: 256 master clocks per sample, 1: 384 |
| mode | input | 3 | Serial format code. 000-010 idle, 011-111 master formats |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Channel clock, high during the left half |
| fsync | output | 1 | Frame-sync strobe |

## Verification
The bench checks that the first `lrclk` rise comes exactly one master clock after enable, with `bclk` low. A divider that restarts at a random phase, or that restarts with `bclk` high, would move the first edge or give a short first bit. For every format and ratio pair it measures the first `fsync` offset in the frame and the number of high cycles. This catches a strobe that is one bit early or late, one that covers 15 or 17 bits, or one placed by the wrong format rule. It drops the enable while `bclk` is high and expects silence one clock later, and it holds the slave codes with the enable high. An implementation that drained the current bit, or that treated every code as a master format, would leave clocks toggling.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [2:0] {
        FMT_SLV_A     = 3'b000,
        FMT_SLV_B     = 3'b001,
        FMT_SLV_C     = 3'b010,
        FMT_W16_FRAME = 3'b011,
        FMT_W18_MSB   = 3'b100,
        FMT_W18_LSB   = 3'b101,
        FMT_NAR_MSB   = 3'b110,
        FMT_NAR_LSB   = 3'b111
    } scg_fmt_e;

    function automatic logic fmt_is_master(input logic [2:0] m);
        return m >= FMT_W16_FRAME;
    endfunction

    function automatic logic fmt_is_narrow(input logic [2:0] m);
        return m[2] & m[1];
    endfunction

endpackage

// File: rtl/scg_bit_div.sv
module scg_bit_div #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [PW-1:0] div_last_i,
    input  logic [PW-1:0] div_half_i,
    output logic          step_o,
    output logic          bclk_o
);
    typedef struct packed {
        logic [PW-1:0] phase;
        logic          bclk;
    } div_st_t;

    div_st_t s_d, s_q;
    logic    step;

    always_comb begin
        s_d  = s_q;
        step = run_i && (s_q.phase >= div_last_i);
        if (!run_i) begin
            s_d.phase = '1;
            s_d.bclk  = 1'b0;
        end else begin
            s_d.phase = step ? '0 : s_q.phase + 1'b1;
            s_d.bclk  = (s_d.phase >= div_half_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= '1;
            s_q.bclk  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign step_o = step;
    assign bclk_o = s_q.bclk;

    // R5
    bclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !bclk_o);
endmodule

// File: rtl/scg_frame_cnt.sv
module scg_frame_cnt #(
    parameter int BW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          step_i,
    input  logic [BW-1:0] bit_last_i,
    input  logic [BW-1:0] half_bits_i,
    output logic [BW-1:0] bit_next_o,
    output logic          lrclk_o
);
    typedef struct packed {
        logic [BW-1:0] bitidx;
        logic          lr;
    } frm_st_t;

    frm_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d.bitidx = '1;
            s_d.lr     = 1'b0;
        end else if (step_i) begin
            s_d.bitidx = (s_q.bitidx >= bit_last_i) ? '0 : s_q.bitidx + 1'b1;
            s_d.lr     = (s_d.bitidx < half_bits_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.bitidx <= '1;
            s_q.lr     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_next_o = s_d.bitidx;
    assign lrclk_o    = s_q.lr;

    // R2
    lr_rise_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lrclk_o) |-> $past(step_i));
endmodule

// File: rtl/scg_fsync_dec.sv
module scg_fsync_dec #(
    parameter int BW         = 6,
    parameter int WORD_LONG  = 18,
    parameter int WORD_SHORT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          step_i,
    input  logic [2:0]    mode_i,
    input  logic [BW-1:0] half_bits_i,
    input  logic [BW-1:0] bit_next_i,
    output logic          fsync_o
);
    import scg_pkg::*;

    localparam logic [BW-1:0] SHORT_END = BW'(WORD_SHORT);
    localparam logic [BW-1:0] LONG_LEAD = BW'(WORD_LONG + 1);

    typedef struct packed {
        logic fs;
    } fs_st_t;

    fs_st_t        s_d, s_q;
    logic [BW-1:0] pos;
    logic          hit;

    always_comb begin
        pos = bit_next_i & (half_bits_i - 1'b1);
        case (scg_fmt_e'(mode_i))
            FMT_W16_FRAME: hit = (pos >= BW'(1)) && (pos <= SHORT_END);
            FMT_W18_MSB,
            FMT_NAR_MSB,
            FMT_NAR_LSB:   hit = (pos == half_bits_i - 1'b1);
            FMT_W18_LSB:   hit = (pos == half_bits_i - LONG_LEAD);
            default:       hit = 1'b0;
        endcase
        s_d = s_q;
        if (!run_i)      s_d.fs = 1'b0;
        else if (step_i) s_d.fs = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.fs <= 1'b0;
        else        s_q    <= s_d;
    end

    assign fsync_o = s_q.fs;

    // R10
    fs_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o |-> $past(run_i));
endmodule

// File: rtl/scg_master_clkgen.sv
module scg_master_clkgen #(
    parameter int FRAME_LO    = 256,
    parameter int FRAME_HI    = 384,
    parameter int BITS_WIDE   = 64,
    parameter int BITS_NARROW = 32,
    parameter int WORD_LONG   = 18,
    parameter int WORD_SHORT  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_on,
    input  logic       ratio_sel,
    input  logic [2:0] mode,
    output logic       bclk,
    output logic       lrclk,
    output logic       fsync
);
    import scg_pkg::*;

    localparam int DIV_LO_W = FRAME_LO / BITS_WIDE;
    localparam int DIV_HI_W = FRAME_HI / BITS_WIDE;
    localparam int DIV_LO_N = FRAME_LO / BITS_NARROW;
    localparam int DIV_HI_N = FRAME_HI / BITS_NARROW;
    localparam int PW       = $clog2(DIV_HI_N + 1);
    localparam int BW       = $clog2(BITS_WIDE);

    logic          run, narrow, step;
    logic [PW-1:0] div_last, div_half;
    logic [BW-1:0] bit_last, half_bits, bit_next;

    always_comb begin
        run       = pwr_on && fmt_is_master(mode);
        narrow    = fmt_is_narrow(mode);
        bit_last  = narrow ? BW'(BITS_NARROW - 1) : BW'(BITS_WIDE - 1);
        half_bits = narrow ? BW'(BITS_NARROW / 2) : BW'(BITS_WIDE / 2);
        case ({narrow, ratio_sel})
            2'b00:   begin div_last = PW'(DIV_LO_W - 1); div_half = PW'(DIV_LO_W / 2); end
            2'b01:   begin div_last = PW'(DIV_HI_W - 1); div_half = PW'(DIV_HI_W / 2); end
            2'b10:   begin div_last = PW'(DIV_LO_N - 1); div_half = PW'(DIV_LO_N / 2); end
            default: begin div_last = PW'(DIV_HI_N - 1); div_half = PW'(DIV_HI_N / 2); end
        endcase
    end

    scg_bit_div #(.PW(PW)) u_div (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .div_last_i(div_last), .div_half_i(div_half),
        .step_o(step), .bclk_o(bclk)
    );

    scg_frame_cnt #(.BW(BW)) u_frm (
        .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(step),
        .bit_last_i(bit_last), .half_bits_i(half_bits),
        .bit_next_o(bit_next), .lrclk_o(lrclk)
    );

    scg_fsync_dec #(.BW(BW), .WORD_LONG(WORD_LONG), .WORD_SHORT(WORD_SHORT)) u_fs (
        .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(step),
        .mode_i(mode), .half_bits_i(half_bits), .bit_next_i(bit_next),
        .fsync_o(fsync)
    );

    // R4
    lr_on_bclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk) |-> !bclk);

    // R4
    fs_on_bclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsync) |-> !bclk);

    // R5
    pwr_off_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (!bclk && !lrclk && !fsync));
endmodule

// File: tb/scg_master_clkgen_test.sv
module scg_master_clkgen_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       ratio;
        logic [2:0] mode;
        logic [3:0] div;
        logic [6:0] bits;
        logic [8:0] fs_first;
        logic [8:0] fs_cnt;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'b011, 4'd4,  7'd64, 9'd4,   9'd128},
        '{1'b1, 3'b011, 4'd6,  7'd64, 9'd6,   9'd192},
        '{1'b0, 3'b100, 4'd4,  7'd64, 9'd124, 9'd8},
        '{1'b1, 3'b100, 4'd6,  7'd64, 9'd186, 9'd12},
        '{1'b1, 3'b101, 4'd6,  7'd64, 9'd78,  9'd12},
        '{1'b0, 3'b101, 4'd4,  7'd64, 9'd52,  9'd8},
        '{1'b0, 3'b110, 4'd8,  7'd32, 9'd120, 9'd16},
        '{1'b1, 3'b111, 4'd12, 7'd32, 9'd180, 9'd24}
    };

    logic clk = 1'b0, rst_n = 1'b0, pwr_on = 1'b0, ratio_sel = 1'b0;
    logic [2:0] mode = 3'b000;
    logic bclk, lrclk, fsync;
    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scg_master_clkgen uut (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .ratio_sel(ratio_sel),
        .mode(mode), .bclk(bclk), .lrclk(lrclk), .fsync(fsync)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_cycles(3);
        // R1: reset state
        check("R1", "outputs in reset", {bclk, lrclk, fsync}, 0);
        rst_n = 1'b1;
        idle_cycles(5);
        check("R1", "outputs after reset, powered down", {bclk, lrclk, fsync}, 0);

        for (int v = 0; v < NVEC; v++) begin
            int frame, lr_hi, bk_hi, bk_rise, fs_hi, fs_first, prev_bk, prev_lr;
            string fs_tag;
            frame = int'(VECS[v].div) * int'(VECS[v].bits);
            fs_tag = (VECS[v].mode == 3'b011) ? "R7" : (VECS[v].mode == 3'b101) ? "R9" : "R8";
            pwr_on = 1'b0;
            ratio_sel = VECS[v].ratio;
            mode = VECS[v].mode;
            idle_cycles(2);
            pwr_on = 1'b1;
            lr_hi = 0; bk_hi = 0; bk_rise = 0; fs_hi = 0; fs_first = -1;
            prev_bk = 0; prev_lr = 0;
            for (int k = 0; k < frame; k++) begin
                @(negedge clk);
                if (k == 0) begin
                    // R6: first left period begins one master clock after enable
                    check("R6", "lrclk at first clock after enable", lrclk, 1);
                    check("R6", "bclk at first clock after enable", bclk, 0);
                end
                lr_hi += lrclk;
                bk_hi += bclk;
                if (bclk && !prev_bk) bk_rise++;
                if (fsync) begin
                    fs_hi++;
                    if (fs_first < 0) fs_first = k;
                end
                prev_bk = bclk;
                prev_lr = lrclk;
            end
            @(negedge clk);
            check("R2", "lrclk low in last cycle of frame", prev_lr, 0);
            check("R2", "lrclk high again after one frame", lrclk, 1);
            check("R2", "lrclk high cycles per frame", lr_hi, frame / 2);
            check("R3", "bclk periods per frame", bk_rise, int'(VECS[v].bits));
            check("R3", "bclk high cycles per frame", bk_hi, frame / 2);
            check(fs_tag, "fsync first offset", fs_first, int'(VECS[v].fs_first));
            check(fs_tag, "fsync high cycles per frame", fs_hi, int'(VECS[v].fs_cnt));
            pwr_on = 1'b0;
            @(negedge clk);
            check("R5", "outputs one clock after power-down", {bclk, lrclk, fsync}, 0);
        end

        // R5: drop the enable while bclk is high, mid-frame
        pwr_on = 1'b0; ratio_sel = 1'b0; mode = 3'b100;
        idle_cycles(2);
        pwr_on = 1'b1;
        idle_cycles(71);
        check("R5", "bclk high before mid-frame power-down", bclk, 1);
        pwr_on = 1'b0;
        @(negedge clk);
        check("R5", "outputs after mid-frame power-down", {bclk, lrclk, fsync}, 0);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                seen += bclk + lrclk + fsync;
            end
            check("R5", "activity while powered down", seen, 0);
        end
        pwr_on = 1'b1;
        @(negedge clk);
        check("R6", "lrclk on restart", lrclk, 1);
        check("R6", "bclk on restart", bclk, 0);

        // R10: slave codes keep the generator idle
        for (int m = 0; m < 3; m++) begin
            int seen;
            pwr_on = 1'b0;
            mode = 3'(m);
            @(negedge clk);
            pwr_on = 1'b1;
            seen = 0;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                seen += bclk + lrclk + fsync;
            end
            check("R10", "activity with slave code", seen, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule